// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, in every cycle, which pipeline registers of a five-stage processor keep their contents (stall) and which are cleared to a nop-equivalent state (bubble). It looks at the instruction kinds held in decode, execute and memory, the decode source registers, the execute load destination, the execute branch outcome and the memory and write-back status codes. From these it resolves four situations: a load followed at once by a use of the loaded register, a return whose target is not known yet, a conditional jump that was wrongly predicted as taken, and an exception that must not be followed by any visible state change.

The unit is purely combinational and sits beside the datapath registers, which consume its stall and bubble vectors at their next clock edge. It also gives the write enable for the condition flags and the processor status that software would see.

Top module: `hazard_ctl`

## Requirements
- R1: A load/use hazard exists when the execute instruction code is a memory load (5) or a pop (11), its destination register is not the "no register" code 15, and it equals either decode source register. It then sets the stall bits for F (bit 0) and D (bit 1) and the bubble bit for E (bit 2) of the stall and bubble vectors (bit 0 F, 1 D, 2 E, 3 M, 4 W).
- R2: A return (code 9) in any of decode, execute or memory stalls F and bubbles D.
- R3: When a return is pending and a load/use hazard exists in the same cycle, D is stalled and not bubbled, F is stalled and E is bubbled.
- R4: A conditional jump (code 7) in execute whose condition input is 0 bubbles D and E; with the condition input at 1 no control bit is set by the jump.
- R5: M is bubbled when the memory-stage or write-back status is an exception code: halt (2), address error (3) or invalid instruction (4).
- R6: W is stalled when the write-back status is an exception code.
- R7: The condition-flag write enable is 1 only when execute holds an arithmetic operation (code 6) and neither the memory nor the write-back status is an exception code.
- R8: The processor status equals the write-back status, except that a bubble status (0) is reported as ok (1).
- R9: No pipeline register is ever stalled and bubbled in the same cycle; E and M are never stalled and F and W are never bubbled.
- R10: With no load/use hazard, return, mispredict or exception present, every stall and bubble bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_icode_i | input | 4 | Instruction code in decode |
| e_icode_i | input | 4 | Instruction code in execute |
| m_icode_i | input | 4 | Instruction code in memory |
| d_src_a_i | input | 4 | Decode first source register ID |
| d_src_b_i | input | 4 | Decode second source register ID |
| e_dst_m_i | input | 4 | Execute load destination register ID |
| e_cnd_i | input | 1 | Execute branch condition (1 taken) |
| m_stat_i | input | 3 | Status computed by the memory stage |
| w_stat_i | input | 3 | Status held in the write-back register |
| stall_o | output | 5 | Per-register stall, bit 0 F to bit 4 W |
| bubble_o | output | 5 | Per-register bubble, bit 0 F to bit 4 W |
| cc_wen_o | output | 1 | Condition-flag write enable |
| cpu_stat_o | output | 3 | Processor status |

## Verification
The hardest case to reach is a return in decode that reads the stack pointer while a load to that same register sits in execute, because it is the only point where one register (D) has a reason to stall and a reason to bubble at once. The vector table builds it directly by placing the return code in decode, a load in execute and matching register IDs, and sets mispredict-with-return and exception-with-operation overlaps beside it. An exhaustive sweep over decode and execute codes with both branch outcomes then checks that stall and bubble never coincide on any register.

// File: rtl/hcu_pkg.sv
package hcu_pkg;

    localparam int ICODE_W = 4;
    localparam int REG_W   = 4;
    localparam int STAT_W  = 3;
    localparam int N_STAGE = 5;
    localparam int N_COND  = 6;

    // stage indices into the stall / bubble vectors
    localparam int S_F = 0;
    localparam int S_D = 1;
    localparam int S_E = 2;
    localparam int S_M = 3;
    localparam int S_W = 4;

    typedef enum logic [ICODE_W-1:0] {
        IC_HALT  = 4'h0,
        IC_NOP   = 4'h1,
        IC_RRMOV = 4'h2,
        IC_IRMOV = 4'h3,
        IC_STORE = 4'h4,
        IC_LOAD  = 4'h5,
        IC_ALU   = 4'h6,
        IC_JCC   = 4'h7,
        IC_CALL  = 4'h8,
        IC_RET   = 4'h9,
        IC_PUSH  = 4'hA,
        IC_POP   = 4'hB
    } icode_e;

    typedef enum logic [STAT_W-1:0] {
        ST_BUB = 3'd0,
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } stat_e;

    localparam logic [REG_W-1:0] REG_NONE = '1;

    // hazard condition vector bit positions
    localparam int C_LU     = 0;  // load/use
    localparam int C_RET    = 1;  // return pending
    localparam int C_MISP   = 2;  // mispredicted jump
    localparam int C_RET_NL = 3;  // return pending without load/use
    localparam int C_EXC_MW = 4;  // exception in memory or write-back
    localparam int C_EXC_W  = 5;  // exception in write-back

    typedef logic [N_COND-1:0] cond_t;

    localparam cond_t M_LU     = cond_t'(1) << C_LU;
    localparam cond_t M_RET    = cond_t'(1) << C_RET;
    localparam cond_t M_MISP   = cond_t'(1) << C_MISP;
    localparam cond_t M_RET_NL = cond_t'(1) << C_RET_NL;
    localparam cond_t M_EXC_MW = cond_t'(1) << C_EXC_MW;
    localparam cond_t M_EXC_W  = cond_t'(1) << C_EXC_W;

    // which conditions hold / clear each register, index = stage
    localparam cond_t STALL_SEL [N_STAGE] = '{
        M_LU | M_RET,        // F
        M_LU,                // D
        cond_t'(0),          // E
        cond_t'(0),          // M
        M_EXC_W              // W
    };

    localparam cond_t BUBBLE_SEL [N_STAGE] = '{
        cond_t'(0),          // F
        M_MISP | M_RET_NL,   // D
        M_LU | M_MISP,       // E
        M_EXC_MW,            // M
        cond_t'(0)           // W
    };

    function automatic logic is_exc(input logic [STAT_W-1:0] s);
        return (s == ST_HLT) || (s == ST_ADR) || (s == ST_INS);
    endfunction

    function automatic logic is_loader(input logic [ICODE_W-1:0] ic);
        return (ic == IC_LOAD) || (ic == IC_POP);
    endfunction

endpackage

// File: rtl/hcu_hazard_detect.sv
module hcu_hazard_detect
    import hcu_pkg::*;
(
    input  logic [ICODE_W-1:0] d_icode_i,
    input  logic [ICODE_W-1:0] e_icode_i,
    input  logic [ICODE_W-1:0] m_icode_i,
    input  logic [REG_W-1:0]   d_src_a_i,
    input  logic [REG_W-1:0]   d_src_b_i,
    input  logic [REG_W-1:0]   e_dst_m_i,
    input  logic               e_cnd_i,
    output logic               load_use_o,
    output logic               ret_pend_o,
    output logic               mispred_o
);

    logic dst_valid;
    logic src_match;

    always_comb begin
        dst_valid  = (e_dst_m_i != REG_NONE);
        src_match  = (e_dst_m_i == d_src_a_i) || (e_dst_m_i == d_src_b_i);
        load_use_o = is_loader(e_icode_i) && dst_valid && src_match;
        ret_pend_o = (d_icode_i == IC_RET) || (e_icode_i == IC_RET)
                   || (m_icode_i == IC_RET);
        mispred_o  = (e_icode_i == IC_JCC) && !e_cnd_i;
    end

endmodule

// File: rtl/hcu_exc_guard.sv
module hcu_exc_guard
    import hcu_pkg::*;
(
    input  logic [ICODE_W-1:0] e_icode_i,
    input  logic [STAT_W-1:0]  m_stat_i,
    input  logic [STAT_W-1:0]  w_stat_i,
    output logic               exc_mw_o,
    output logic               exc_w_o,
    output logic               cc_wen_o,
    output logic [STAT_W-1:0]  cpu_stat_o
);

    always_comb begin
        exc_w_o    = is_exc(w_stat_i);
        exc_mw_o   = is_exc(m_stat_i) || exc_w_o;
        cc_wen_o   = (e_icode_i == IC_ALU) && !exc_mw_o;
        cpu_stat_o = (w_stat_i == ST_BUB) ? STAT_W'(ST_AOK) : w_stat_i;
    end

endmodule

// File: rtl/hcu_stage_ctl.sv
module hcu_stage_ctl
    import hcu_pkg::*;
(
    input  cond_t              cond_i,
    output logic [N_STAGE-1:0] stall_o,
    output logic [N_STAGE-1:0] bubble_o
);

    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        assign stall_o[s]  = |(cond_i & STALL_SEL[s]);
        assign bubble_o[s] = |(cond_i & BUBBLE_SEL[s]);
    end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hcu_pkg::*;
(
    input  logic [ICODE_W-1:0] d_icode_i,
    input  logic [ICODE_W-1:0] e_icode_i,
    input  logic [ICODE_W-1:0] m_icode_i,
    input  logic [REG_W-1:0]   d_src_a_i,
    input  logic [REG_W-1:0]   d_src_b_i,
    input  logic [REG_W-1:0]   e_dst_m_i,
    input  logic               e_cnd_i,
    input  logic [STAT_W-1:0]  m_stat_i,
    input  logic [STAT_W-1:0]  w_stat_i,
    output logic [N_STAGE-1:0] stall_o,
    output logic [N_STAGE-1:0] bubble_o,
    output logic               cc_wen_o,
    output logic [STAT_W-1:0]  cpu_stat_o
);

    logic  load_use;
    logic  ret_pend;
    logic  mispred;
    logic  exc_mw;
    logic  exc_w;
    cond_t cond;

    hcu_hazard_detect u_det (
        .d_icode_i  (d_icode_i),
        .e_icode_i  (e_icode_i),
        .m_icode_i  (m_icode_i),
        .d_src_a_i  (d_src_a_i),
        .d_src_b_i  (d_src_b_i),
        .e_dst_m_i  (e_dst_m_i),
        .e_cnd_i    (e_cnd_i),
        .load_use_o (load_use),
        .ret_pend_o (ret_pend),
        .mispred_o  (mispred)
    );

    hcu_exc_guard u_exc (
        .e_icode_i  (e_icode_i),
        .m_stat_i   (m_stat_i),
        .w_stat_i   (w_stat_i),
        .exc_mw_o   (exc_mw),
        .exc_w_o    (exc_w),
        .cc_wen_o   (cc_wen_o),
        .cpu_stat_o (cpu_stat_o)
    );

    // the return case defers to load/use on D so D is never both held and cleared
    always_comb begin
        cond           = '0;
        cond[C_LU]     = load_use;
        cond[C_RET]    = ret_pend;
        cond[C_MISP]   = mispred;
        cond[C_RET_NL] = ret_pend && !load_use;
        cond[C_EXC_MW] = exc_mw;
        cond[C_EXC_W]  = exc_w;
    end

    hcu_stage_ctl u_stg (
        .cond_i   (cond),
        .stall_o  (stall_o),
        .bubble_o (bubble_o)
    );

endmodule

// File: rtl/hcu_checker.sv
module hcu_checker
    import hcu_pkg::*;
(
    input logic [ICODE_W-1:0] d_icode_i,
    input logic [ICODE_W-1:0] e_icode_i,
    input logic [ICODE_W-1:0] m_icode_i,
    input logic [REG_W-1:0]   d_src_a_i,
    input logic [REG_W-1:0]   d_src_b_i,
    input logic [REG_W-1:0]   e_dst_m_i,
    input logic               e_cnd_i,
    input logic [STAT_W-1:0]  m_stat_i,
    input logic [STAT_W-1:0]  w_stat_i,
    input logic [N_STAGE-1:0] stall_o,
    input logic [N_STAGE-1:0] bubble_o,
    input logic               cc_wen_o,
    input logic [STAT_W-1:0]  cpu_stat_o
);

    logic lu_seen;
    logic ret_seen;
    logic w_bad;
    logic any_bad;

    always_comb begin
        lu_seen  = ((e_icode_i == 4'h5) || (e_icode_i == 4'hB)) && (e_dst_m_i != 4'hF)
                 && ((e_dst_m_i == d_src_a_i) || (e_dst_m_i == d_src_b_i));
        ret_seen = (d_icode_i == 4'h9) || (e_icode_i == 4'h9) || (m_icode_i == 4'h9);
        w_bad    = (w_stat_i >= 3'd2) && (w_stat_i <= 3'd4);
        any_bad  = w_bad || ((m_stat_i >= 3'd2) && (m_stat_i <= 3'd4));

        a_r9_no_stall_and_bubble: assert ((stall_o & bubble_o) == '0)
            else $error("R9 stall and bubble overlap");
        a_r1_load_use_holds_fd: assert (!lu_seen || (stall_o[0] && stall_o[1] && bubble_o[2]))
            else $error("R1 load/use controls missing");
        a_r3_d_not_cleared_on_lu: assert (!lu_seen || !bubble_o[1])
            else $error("R3 D bubbled during load/use");
        a_r2_ret_stalls_f: assert (!ret_seen || stall_o[0])
            else $error("R2 F not stalled on return");
        a_r4_mispredict_clears_de: assert (!((e_icode_i == 4'h7) && !e_cnd_i) || (bubble_o[1] && bubble_o[2]))
            else $error("R4 mispredict not squashed");
        a_r5_exc_clears_m: assert (bubble_o[3] == any_bad)
            else $error("R5 M bubble wrong");
        a_r6_w_exc_holds_w: assert (stall_o[4] == w_bad)
            else $error("R6 W stall wrong");
        a_r7_cc_quiet_on_exc: assert (!any_bad || !cc_wen_o)
            else $error("R7 flags written under exception");
        a_r8_status_never_bubble: assert (cpu_stat_o != 3'd0)
            else $error("R8 bubble status leaked");
    end

endmodule

bind hazard_ctl hcu_checker u_chk (
    .d_icode_i  (d_icode_i),
    .e_icode_i  (e_icode_i),
    .m_icode_i  (m_icode_i),
    .d_src_a_i  (d_src_a_i),
    .d_src_b_i  (d_src_b_i),
    .e_dst_m_i  (e_dst_m_i),
    .e_cnd_i    (e_cnd_i),
    .m_stat_i   (m_stat_i),
    .w_stat_i   (w_stat_i),
    .stall_o    (stall_o),
    .bubble_o   (bubble_o),
    .cc_wen_o   (cc_wen_o),
    .cpu_stat_o (cpu_stat_o)
);

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    typedef struct packed {
        logic [3:0] d_ic;
        logic [3:0] e_ic;
        logic [3:0] m_ic;
        logic [3:0] sa;
        logic [3:0] sb;
        logic [3:0] dm;
        logic       cnd;
        logic [2:0] ms;
        logic [2:0] ws;
        logic [4:0] xs;    // expected stall, {W,M,E,D,F}
        logic [4:0] xb;    // expected bubble, {W,M,E,D,F}
        logic       xcc;
        logic [2:0] xst;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TAB [NV] = '{
        // R10 idle pipeline
        '{4'h1,4'h1,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd1,5'b00000,5'b00000,1'b0,3'd1,4'd10},
        // R1 load to srcA
        '{4'h6,4'h5,4'h1,4'h3,4'hF,4'h3,1'b1,3'd1,3'd1,5'b00011,5'b00100,1'b0,3'd1,4'd1},
        // R1 pop to srcB
        '{4'h6,4'hB,4'h1,4'h2,4'h7,4'h7,1'b1,3'd1,3'd1,5'b00011,5'b00100,1'b0,3'd1,4'd1},
        // R10 load without matching source
        '{4'h6,4'h5,4'h1,4'h2,4'h4,4'h3,1'b1,3'd1,3'd1,5'b00000,5'b00000,1'b0,3'd1,4'd10},
        // R1 destination code 15 never matches
        '{4'h6,4'h5,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd1,5'b00000,5'b00000,1'b0,3'd1,4'd1},
        // R2 return in decode
        '{4'h9,4'h1,4'h1,4'h4,4'h4,4'hF,1'b1,3'd1,3'd1,5'b00001,5'b00010,1'b0,3'd1,4'd2},
        // R2 return in execute
        '{4'h1,4'h9,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd1,5'b00001,5'b00010,1'b0,3'd1,4'd2},
        // R2 return in memory
        '{4'h1,4'h1,4'h9,4'hF,4'hF,4'hF,1'b1,3'd1,3'd1,5'b00001,5'b00010,1'b0,3'd1,4'd2},
        // R3 return in decode reading a loaded register
        '{4'h9,4'h5,4'h1,4'h4,4'h4,4'h4,1'b1,3'd1,3'd1,5'b00011,5'b00100,1'b0,3'd1,4'd3},
        // R4 not-taken jump
        '{4'h1,4'h7,4'h1,4'hF,4'hF,4'hF,1'b0,3'd1,3'd1,5'b00000,5'b00110,1'b0,3'd1,4'd4},
        // R4 taken jump
        '{4'h1,4'h7,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd1,5'b00000,5'b00000,1'b0,3'd1,4'd4},
        // R7 operation updates flags
        '{4'h1,4'h6,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd1,5'b00000,5'b00000,1'b1,3'd1,4'd7},
        // R5 address error in memory
        '{4'h1,4'h6,4'h1,4'hF,4'hF,4'hF,1'b1,3'd3,3'd1,5'b00000,5'b01000,1'b0,3'd1,4'd5},
        // R6 halt in write-back
        '{4'h1,4'h6,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd2,5'b10000,5'b01000,1'b0,3'd2,4'd6},
        // R6 invalid instruction in write-back
        '{4'h1,4'h1,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd4,5'b10000,5'b01000,1'b0,3'd4,4'd6},
        // R8 bubble in write-back reads as ok
        '{4'h1,4'h6,4'h1,4'hF,4'hF,4'hF,1'b1,3'd1,3'd0,5'b00000,5'b00000,1'b1,3'd1,4'd8},
        // R8 bubble status in memory is no exception
        '{4'h1,4'h6,4'h1,4'hF,4'hF,4'hF,1'b1,3'd0,3'd1,5'b00000,5'b00000,1'b1,3'd1,4'd8},
        // R2 and R4 together: mispredict with return in memory
        '{4'h1,4'h7,4'h9,4'hF,4'hF,4'hF,1'b0,3'd1,3'd1,5'b00001,5'b00110,1'b0,3'd1,4'd4}
    };

    logic       clk = 1'b0;
    logic [3:0] d_icode, e_icode, m_icode, src_a, src_b, dst_m;
    logic       cnd;
    logic [2:0] m_stat, w_stat;
    logic [4:0] stall, bubble;
    logic       cc_wen;
    logic [2:0] cpu_stat;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctl u0 (
        .d_icode_i  (d_icode),
        .e_icode_i  (e_icode),
        .m_icode_i  (m_icode),
        .d_src_a_i  (src_a),
        .d_src_b_i  (src_b),
        .e_dst_m_i  (dst_m),
        .e_cnd_i    (cnd),
        .m_stat_i   (m_stat),
        .w_stat_i   (w_stat),
        .stall_o    (stall),
        .bubble_o   (bubble),
        .cc_wen_o   (cc_wen),
        .cpu_stat_o (cpu_stat)
    );

    task automatic check_vec(input vec_t v, input int idx);
        d_icode = v.d_ic; e_icode = v.e_ic; m_icode = v.m_ic;
        src_a = v.sa; src_b = v.sb; dst_m = v.dm;
        cnd = v.cnd; m_stat = v.ms; w_stat = v.ws;
        @(negedge clk);
        checks++;
        if (stall !== v.xs || bubble !== v.xb || cc_wen !== v.xcc || cpu_stat !== v.xst) begin
            errors++;
            $display("FAIL R%0d vector %0d: stall=%b bubble=%b cc=%b stat=%0d expected stall=%b bubble=%b cc=%b stat=%0d",
                     v.req, idx, stall, bubble, cc_wen, cpu_stat, v.xs, v.xb, v.xcc, v.xst);
        end
    endtask

    initial begin
        d_icode = 4'h1; e_icode = 4'h1; m_icode = 4'h1;
        src_a = 4'hF; src_b = 4'hF; dst_m = 4'hF;
        cnd = 1'b1; m_stat = 3'd1; w_stat = 3'd1;
        @(negedge clk);
        // reset-like idle state: R10
        checks++;
        if (stall !== 5'b0 || bubble !== 5'b0 || cpu_stat !== 3'd1) begin
            errors++;
            $display("FAIL R10 idle: stall=%b bubble=%b stat=%0d expected 00000 00000 1",
                     stall, bubble, cpu_stat);
        end

        for (int i = 0; i < NV; i++) check_vec(TAB[i], i);

        // R9 sweep: every decode/execute code, both outcomes, load hazard forced
        for (int di = 0; di < 16; di++) begin
            for (int ei = 0; ei < 16; ei++) begin
                for (int c = 0; c < 2; c++) begin
                    d_icode = 4'(di); e_icode = 4'(ei); m_icode = 4'h1;
                    src_a = 4'h4; src_b = 4'hF; dst_m = 4'h4;
                    cnd = c[0]; m_stat = 3'd1; w_stat = 3'd1;
                    @(negedge clk);
                    checks++;
                    if ((stall & bubble) !== 5'b0 || stall[2] !== 1'b0 || stall[3] !== 1'b0
                        || bubble[0] !== 1'b0 || bubble[4] !== 1'b0) begin
                        errors++;
                        $display("FAIL R9 d=%0d e=%0d cnd=%0d: stall=%b bubble=%b expected disjoint",
                                 di, ei, c, stall, bubble);
                    end
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule